// File: doc/BRIEF.md
# Amplifier Reset and Power-Down Sequencer

This controller owns the run state of a multichannel PWM audio output stage. It takes two active-low controls, a full asynchronous reset and a power-down request, and from them drives the master-volume command, a hard-mute indicator, clock and logic enables, soft-start and soft-stop requests to the PWM ramp logic, and two registered output-valid flags. The ramp logic answers each soft-start or soft-stop request with a one-cycle ramp-done pulse.

The two controls behave differently. Reset clears a small configuration register file, forces hard mute and full attenuation at once, and on release runs a timed initialization that leaves the volume muted. Power-down keeps the configuration: it ramps the output down, gates clocks and logic, and on release waits a fixed recovery time before ramping back up to the volume that was in force. Register 0 of the file is the master volume, and all-ones in it means full attenuation. Both timed intervals and the soft-stop timeout are counted in reference-clock cycles set by parameters (4.5 ms initialization and 100 ms recovery by default).

Top module: `amp_run_seq`

## Requirements
- R1: While `rst_ni` is low, and immediately on its fall without waiting for a clock edge, `vol_o` is all ones, `hard_mute_o` is 1, both valid flags are 0, and the configuration file returns to defaults (register 0 all ones, every other register 0).
- R2: After `rst_ni` rises, the block stays in reset until `pdn_ni` is high. It then spends exactly `INIT_CYC` cycles in initialization with `hard_mute_o` = 1, `vol_o` all ones and both valid flags 0.
- R3: Initialization ends in a muted run state: `vol_o` all ones, `hard_mute_o` 0, `pwm_ss_valid_o` 1, `pwm_valid_o` 0. The block leaves this state for soft start on the cycle after register 0 holds a value other than all ones.
- R4: During soft start, `soft_start_o` is 1, `vol_o` equals register 0 and `pwm_ss_valid_o` is 1. A `ramp_done_i` pulse moves the block to run, where `pwm_valid_o` is 1 and `soft_start_o` is 0.
- R5: `pdn_ni` low during initialization, muted run, soft start or run moves the block on the next edge to soft stop: `soft_stop_o` 1, `pwm_valid_o` 0, `pwm_ss_valid_o` 1, `vol_o` equal to register 0.
- R6: Soft stop ends, and the block powers down, on `ramp_done_i` or after `STOP_TO_CYC` cycles without it.
- R7: When powered down, `clk_en_o` and `logic_en_o` are 0, `hard_mute_o` is 1, `vol_o` is all ones and both valid flags are 0. Configuration writes are ignored and the register contents are kept.
- R8: `pdn_ni` high while powered down starts recovery: enables back at 1 and `hard_mute_o` 1, for `REC_CYC` cycles. Recovery then goes to soft start if register 0 is not all ones, and to muted run if it is. `pdn_ni` low during recovery returns the block to power-down.
- R9: A write (`cfg_we_i`) to the register at `cfg_addr_i` takes effect at the clock edge in every state except reset and power-down. `cfg_rdata_o` always shows the register addressed by `cfg_addr_i`.
- R10: The state register is one-hot, and `pwm_valid_o` is never 1 while `pwm_ss_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdn_ni | input | 1 | Power-down request, active low |
| ramp_done_i | input | 1 | Ramp-complete pulse from the PWM ramp logic |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(N_REG) | Configuration register address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_rdata_o | output | CFG_W | Contents of the addressed register |
| vol_o | output | CFG_W | Master-volume command; all ones is full attenuation |
| hard_mute_o | output | 1 | PWM hard-mute indicator |
| clk_en_o | output | 1 | Clock enable for the output stage |
| logic_en_o | output | 1 | Logic power enable for the output stage |
| soft_start_o | output | 1 | Soft-start request to the ramp logic |
| soft_stop_o | output | 1 | Soft-stop request to the ramp logic |
| pwm_ss_valid_o | output | 1 | Soft-start PWM output valid |
| pwm_valid_o | output | 1 | PWM outputs fully valid |

## Verification
Every output is a decode of the one-hot state or a flop loaded from the next state. A wrong state therefore shows at the ports in the same cycle as a wrong combination of mute, enables, requests and valid flags. The bench walks reset, initialization, ramp-up, run, a ramp-down ended by ramp-done and one ended by timeout, power-down and recovery, and checks that combination after every step. A timer off by one cycle shows as a transition one step early or late at the exact boundary samples. A configuration file that loses data shows as a wrong `vol_o` in soft start after recovery and as a wrong `cfg_rdata_o`.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;
  typedef enum logic [7:0] {
    ST_RESET   = 8'h01,
    ST_INIT    = 8'h02,
    ST_MUTED   = 8'h04,
    ST_SSTART  = 8'h08,
    ST_RUN     = 8'h10,
    ST_SSTOP   = 8'h20,
    ST_PDOWN   = 8'h40,
    ST_RECOVER = 8'h80
  } run_state_e;
endpackage

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

  // last cycle of an interval of limit_i cycles
  assign done_o = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/amp_seq_cfg.sv
module amp_seq_cfg #(
  parameter int N_REG = 8,
  parameter int CFG_W = 8,
  localparam int AW   = $clog2(N_REG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic [CFG_W-1:0] vol_o
);
  logic [CFG_W-1:0] regs_q [N_REG];

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    // register 0 is master volume, defaults to full attenuation
    localparam logic [CFG_W-1:0] DEFV = (g == 0) ? '1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= DEFV;
      else if (we_i && (addr_i == AW'(g)))      regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_REG; k++)
      if (addr_i == AW'(k)) rdata_o = regs_q[k];
  end

  assign vol_o = regs_q[0];
endmodule

// File: rtl/amp_seq_fsm.sv
module amp_seq_fsm
  import amp_seq_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int INIT_CYC    = 225_000,
  parameter int REC_CYC     = 5_000_000,
  parameter int STOP_TO_CYC = 500_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pdn_ni,
  input  logic             ramp_done_i,
  input  logic             vol_mute_i,
  input  logic             tmr_done_i,
  output run_state_e       state_o,
  output run_state_e       next_o,
  output logic             tmr_clr_o,
  output logic [CNT_W-1:0] tmr_limit_o
);
  localparam logic [CNT_W-1:0] LIM_INIT = CNT_W'(INIT_CYC);
  localparam logic [CNT_W-1:0] LIM_REC  = CNT_W'(REC_CYC);
  localparam logic [CNT_W-1:0] LIM_STOP = CNT_W'(STOP_TO_CYC);

  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:   if (pdn_ni) state_d = ST_INIT;
      ST_INIT:    if (!pdn_ni)          state_d = ST_SSTOP;
                  else if (tmr_done_i)  state_d = ST_MUTED;
      ST_MUTED:   if (!pdn_ni)          state_d = ST_SSTOP;
                  else if (!vol_mute_i) state_d = ST_SSTART;
      ST_SSTART:  if (!pdn_ni)          state_d = ST_SSTOP;
                  else if (ramp_done_i) state_d = ST_RUN;
      ST_RUN:     if (!pdn_ni)          state_d = ST_SSTOP;
      ST_SSTOP:   if (ramp_done_i || tmr_done_i) state_d = ST_PDOWN;
      ST_PDOWN:   if (pdn_ni) state_d = ST_RECOVER;
      ST_RECOVER: if (!pdn_ni)          state_d = ST_PDOWN;
                  else if (tmr_done_i)  state_d = vol_mute_i ? ST_MUTED : ST_SSTART;
      default:    state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_INIT:    tmr_limit_o = LIM_INIT;
      ST_RECOVER: tmr_limit_o = LIM_REC;
      default:    tmr_limit_o = LIM_STOP;
    endcase
  end

  assign tmr_clr_o = (state_d != state_q);
  assign state_o   = state_q;
  assign next_o    = state_d;
endmodule

// File: rtl/amp_run_seq.sv
module amp_run_seq
  import amp_seq_pkg::*;
#(
  parameter int REF_HZ      = 50_000_000,
  parameter int INIT_US     = 4_500,
  parameter int REC_US      = 100_000,
  parameter int STOP_US     = 10_000,
  parameter int INIT_CYC    = (REF_HZ / 1_000_000) * INIT_US,
  parameter int REC_CYC     = (REF_HZ / 1_000_000) * REC_US,
  parameter int STOP_TO_CYC = (REF_HZ / 1_000_000) * STOP_US,
  parameter int N_REG       = 8,   // >= 2
  parameter int CFG_W       = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pdn_ni,
  input  logic                     ramp_done_i,
  input  logic                     cfg_we_i,
  input  logic [$clog2(N_REG)-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]         cfg_wdata_i,
  output logic [CFG_W-1:0]         cfg_rdata_o,
  output logic [CFG_W-1:0]         vol_o,
  output logic                     hard_mute_o,
  output logic                     clk_en_o,
  output logic                     logic_en_o,
  output logic                     soft_start_o,
  output logic                     soft_stop_o,
  output logic                     pwm_ss_valid_o,
  output logic                     pwm_valid_o
);
  localparam int MAX_A = (INIT_CYC > REC_CYC) ? INIT_CYC : REC_CYC;
  localparam int MAXC  = (MAX_A > STOP_TO_CYC) ? MAX_A : STOP_TO_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  run_state_e       state_q, next_s;
  logic             tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;
  logic [CFG_W-1:0] vol_cfg;
  logic             vol_mute, cfg_we, ramping;
  logic             ss_valid_q, valid_q;

  assign vol_mute = (vol_cfg == '1);
  assign cfg_we   = cfg_we_i && (state_q != ST_RESET) && (state_q != ST_PDOWN);

  amp_seq_fsm #(
    .CNT_W(CNT_W), .INIT_CYC(INIT_CYC), .REC_CYC(REC_CYC), .STOP_TO_CYC(STOP_TO_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .pdn_ni, .ramp_done_i,
    .vol_mute_i (vol_mute),
    .tmr_done_i (tmr_done),
    .state_o    (state_q),
    .next_o     (next_s),
    .tmr_clr_o  (tmr_clr),
    .tmr_limit_o(tmr_limit)
  );

  amp_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .clr_i  (tmr_clr),
    .limit_i(tmr_limit),
    .done_o (tmr_done)
  );

  amp_seq_cfg #(.N_REG(N_REG), .CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i   (cfg_we),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .vol_o  (vol_cfg)
  );

  // valid flags loaded from next state so they change with the state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_valid_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      ss_valid_q <= (next_s == ST_MUTED) || (next_s == ST_SSTART) ||
                    (next_s == ST_RUN)   || (next_s == ST_SSTOP);
      valid_q    <= (next_s == ST_RUN);
    end
  end

  assign ramping        = (state_q == ST_SSTART) || (state_q == ST_RUN) || (state_q == ST_SSTOP);
  assign vol_o          = ramping ? vol_cfg : '1;
  assign hard_mute_o    = (state_q == ST_RESET) || (state_q == ST_INIT) ||
                          (state_q == ST_PDOWN) || (state_q == ST_RECOVER);
  assign clk_en_o       = (state_q != ST_PDOWN);
  assign logic_en_o     = (state_q != ST_PDOWN);
  assign soft_start_o   = (state_q == ST_SSTART);
  assign soft_stop_o    = (state_q == ST_SSTOP);
  assign pwm_ss_valid_o = ss_valid_q;
  assign pwm_valid_o    = valid_q;
endmodule

// File: rtl/amp_run_seq_chk.sv
module amp_run_seq_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pdn_ni,
  input logic             ramp_done_i,
  input logic [7:0]       state_q,
  input logic [CFG_W-1:0] vol_cfg,
  input logic             hard_mute_o,
  input logic             clk_en_o,
  input logic             logic_en_o,
  input logic             soft_start_o,
  input logic             soft_stop_o,
  input logic             pwm_ss_valid_o,
  input logic             pwm_valid_o
);
  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));

  p_valid_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_valid_o |-> pwm_ss_valid_o);

  p_pd_outputs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_o |-> (hard_mute_o && !pwm_ss_valid_o && !pwm_valid_o));

  p_pd_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !logic_en_o |=> $stable(vol_cfg));

  p_start_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_start_o && ramp_done_i && pdn_ni) |=> (pwm_valid_o && !soft_start_o));

  p_run_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_valid_o && !pdn_ni) |=> (soft_stop_o && !pwm_valid_o));

  p_stop_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_stop_o && ramp_done_i) |=> (!clk_en_o && !soft_stop_o));
endmodule

bind amp_run_seq amp_run_seq_chk #(.CFG_W(CFG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pdn_ni        (pdn_ni),
  .ramp_done_i   (ramp_done_i),
  .state_q       (state_q),
  .vol_cfg       (vol_cfg),
  .hard_mute_o   (hard_mute_o),
  .clk_en_o      (clk_en_o),
  .logic_en_o    (logic_en_o),
  .soft_start_o  (soft_start_o),
  .soft_stop_o   (soft_stop_o),
  .pwm_ss_valid_o(pwm_ss_valid_o),
  .pwm_valid_o   (pwm_valid_o)
);

// File: tb/tb_amp_run_seq.sv
`timescale 1ns/1ps
module tb_amp_run_seq;
  localparam int INIT_C = 10;
  localparam int REC_C  = 20;
  localparam int STOP_C = 8;

  // flag order {hard_mute, clk_en, logic_en, soft_start, soft_stop, ss_valid, valid}
  localparam logic [6:0] F_RST  = 7'b1110000;
  localparam logic [6:0] F_INIT = 7'b1110000;
  localparam logic [6:0] F_MUT  = 7'b0110010;
  localparam logic [6:0] F_SS   = 7'b0111010;
  localparam logic [6:0] F_RUN  = 7'b0110011;
  localparam logic [6:0] F_STOP = 7'b0110110;
  localparam logic [6:0] F_PD   = 7'b1000000;
  localparam logic [6:0] F_REC  = 7'b1110000;

  typedef struct packed {
    logic       rst_n;
    logic       pdn_n;
    logic       ramp;
    logic       we;
    logic [1:0] addr;
    logic [7:0] wd;
    logic [7:0] n;
    logic [7:0] exp_vol;
    logic [7:0] exp_rd;
    logic [6:0] exp_f;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'hFF,F_INIT,4'd2}, // R2 enter init
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd9, 8'hFF,8'hFF,F_INIT,4'd2}, // R2 last init cycle
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'hFF,F_MUT, 4'd3}, // R3 muted run
    '{1'b1,1'b1,1'b0,1'b1,2'd1,8'h5A,8'd1, 8'hFF,8'h5A,F_MUT, 4'd9}, // R9 write reg1
    '{1'b1,1'b1,1'b0,1'b1,2'd0,8'h30,8'd1, 8'hFF,8'h30,F_MUT, 4'd9}, // R9 write volume
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd1, 8'h30,8'h30,F_SS,  4'd3}, // R3 leaves mute
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd3, 8'h30,8'h30,F_SS,  4'd4}, // R4 waits ramp
    '{1'b1,1'b1,1'b1,1'b0,2'd0,8'h00,8'd1, 8'h30,8'h30,F_RUN, 4'd4}, // R4 run
    '{1'b1,1'b1,1'b0,1'b0,2'd1,8'h00,8'd5, 8'h30,8'h5A,F_RUN, 4'd9}, // R9 readback
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'd1, 8'h30,8'h30,F_STOP,4'd5}, // R5 stop from run
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'd2, 8'h30,8'h30,F_STOP,4'd6}, // R6 waiting
    '{1'b1,1'b0,1'b1,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'h30,F_PD,  4'd6}, // R6 ramp done
    '{1'b1,1'b0,1'b0,1'b1,2'd0,8'h77,8'd1, 8'hFF,8'h30,F_PD,  4'd7}, // R7 write ignored
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'h30,F_REC, 4'd8}, // R8 recover
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd19,8'hFF,8'h30,F_REC, 4'd8}, // R8 last cycle
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd1, 8'h30,8'h30,F_SS,  4'd8}, // R8 restores volume
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'd1, 8'h30,8'h30,F_STOP,4'd5}, // R5 abort soft start
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'd7, 8'h30,8'h30,F_STOP,4'd6}, // R6 before timeout
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'h30,F_PD,  4'd6}, // R6 timeout
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'h30,F_REC, 4'd8}, // R8
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'd1, 8'hFF,8'h30,F_PD,  4'd8}  // R8 back to power-down
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, pdn_n = 1'b1, ramp = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd, vol;
  logic       hm, cen, len, ss, st, v1, v2;
  int         nchk = 0, nerr = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  amp_run_seq #(
    .INIT_CYC(INIT_C), .REC_CYC(REC_C), .STOP_TO_CYC(STOP_C), .N_REG(4), .CFG_W(8)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .pdn_ni(pdn_n), .ramp_done_i(ramp),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wd), .cfg_rdata_o(rd),
    .vol_o(vol), .hard_mute_o(hm), .clk_en_o(cen), .logic_en_o(len),
    .soft_start_o(ss), .soft_stop_o(st), .pwm_ss_valid_o(v1), .pwm_valid_o(v2)
  );

  task automatic check(input int req, input logic [7:0] ev, input logic [7:0] er,
                       input logic [6:0] ef);
    logic [6:0] af;
    af = {hm, cen, len, ss, st, v1, v2};
    nchk++;
    if (vol !== ev || rd !== er || af !== ef) begin
      nerr++;
      $display("FAIL R%0d: got vol=%h rd=%h flags=%b, expected vol=%h rd=%h flags=%b",
               req, vol, rd, af, ev, er, ef);
    end
  endtask

  task automatic step(input logic p, input logic r, input int n);
    @(negedge clk);
    pdn_n = p; ramp = r; we = 1'b0;
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(1, 8'hFF, 8'hFF, F_RST);      // R1 reset state, volume register default
    addr = 2'd1; #1;
    check(1, 8'hFF, 8'h00, F_RST);      // R1 other registers clear

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst_n = VEC[i].rst_n; pdn_n = VEC[i].pdn_n; ramp = VEC[i].ramp;
      we = VEC[i].we; addr = VEC[i].addr; wd = VEC[i].wd;
      repeat (int'(VEC[i].n)) @(posedge clk);
      #5;
      check(int'(VEC[i].req), VEC[i].exp_vol, VEC[i].exp_rd, VEC[i].exp_f);
    end

    // R1: async reset in run, seen before any clock edge
    @(negedge clk); we = 1'b0; addr = 2'd0;
    step(1'b1, 1'b0, REC_C + 1);
    check(8, 8'h30, 8'h30, F_SS);       // R8
    step(1'b1, 1'b1, 1);
    check(4, 8'h30, 8'h30, F_RUN);      // R4
    @(negedge clk); ramp = 1'b0;
    @(posedge clk); #5;
    rst_n = 1'b0; #1;
    check(1, 8'hFF, 8'hFF, F_RST);      // R1 immediate
    addr = 2'd1; #1;
    check(1, 8'hFF, 8'h00, F_RST);      // R1 defaults
    addr = 2'd0;

    // R2: release with power-down low holds reset
    @(negedge clk); pdn_n = 1'b0; rst_n = 1'b1;
    repeat (3) @(posedge clk); #5;
    check(2, 8'hFF, 8'hFF, F_RST);
    step(1'b1, 1'b0, 1);
    check(2, 8'hFF, 8'hFF, F_INIT);
    step(1'b1, 1'b0, 4);
    step(1'b0, 1'b0, 1);
    check(5, 8'hFF, 8'hFF, F_STOP);     // R5 abort from init
    step(1'b0, 1'b1, 1);
    check(6, 8'hFF, 8'hFF, F_PD);       // R6
    step(1'b1, 1'b0, REC_C + 1);
    check(8, 8'hFF, 8'hFF, F_MUT);      // R8 muted volume resumes muted run
    step(1'b0, 1'b0, 1);
    check(5, 8'hFF, 8'hFF, F_STOP);     // R5 stop from muted run

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule